// File: doc/BRIEF.md
# Programmable Target/Overflow Timer Channel

This block is a single 16-bit timer channel. Software reaches it through a small register port: a count register, a mode register and a target register. Each cycle the channel may advance its count by one. It advances on every system clock, on a divided clock, or on a pulse of an external line-rate input, and which of these applies depends on the channel variant and the mode word. The count can wrap at a programmed target value or run through the whole 16-bit range. Either event can raise a one-cycle interrupt pulse, once per arming or on every event.

The mode word also holds sticky status bits. These record that a target match or an overflow happened, and they clear when the mode register is read. Writing the mode word restarts the channel from zero and rearms a one-shot interrupt. Three channel variants exist, chosen by a parameter. Each instance drives its own bit of a small interrupt request vector, so several channels can share one request bus.

Top module: `tgt_timer`

## Requirements
- R1: While reset is held, the count, the mode word and the target read as zero and no interrupt bit is set.
- R2: Address 0 selects the count, 1 the mode word and 2 the target. `rdata` shows the selected register in the same cycle. A count write loads the written value at that clock edge, and no advance happens in that cycle.
- R3: When the count advances from 0xFFFF it becomes 0 and mode bit 12 is set (overflow). With mode bit 5 set, the overflow raises an interrupt.
- R4: A target match occurs when an advance would make the count equal a non-zero target. It sets mode bit 11. With mode bit 3 set, the count becomes 0 instead of the target value. With bit 3 clear, the count keeps running. A target of 0 never matches.
- R5: Mode bit 4 enables the interrupt on a target match. The interrupt is a one-cycle high on bit IRQ_IDX of `irq_vec`, in the cycle after the event's clock edge. All other bits stay low.
- R6: With mode bit 6 set, every enabled event pulses the interrupt. With it clear, only the first enabled event after a mode write pulses it.
- R7: A mode read (`rd_en` with address 1) returns the current word. Bits 11 and 12 then clear at that edge. Bit 10 is set by every target or overflow event and stays set.
- R8: A mode write stores the value with bits 13 to 15 forced to zero, sets the count to 0, rearms the one-shot interrupt and restarts the clock divider.
- R9: The advance rate depends on the variant. Variant 0 with mode bit 8 advances once every 5 clocks. Variant 1 with mode bit 8 advances once per `alt_tick` cycle. Variant 2 with mode bit 9 advances once every 8 clocks. Variant 2 with mode bit 0 does not advance. Every other case advances each clock.
- R10: A target write keeps the current count. Later matches are judged against the new target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on mode read) |
| addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| wdata | input | CW | Write data |
| alt_tick | input | 1 | External line-rate pulse (variant 1) |
| rdata | output | CW | Selected register value |
| irq_vec | output | NIRQ | Interrupt request vector, pulse on bit IRQ_IDX |

## Verification
The hardest case to reach from the ports is the overflow wrap, which needs 65536 advances from reset. The stimulus gets there by writing the count a few steps below 0xFFFF, so the wrap and its flag and interrupt come within a handful of cycles. One-shot suppression is reached by letting a wrapping target produce several matches within one arming. Rearming is shown by writing the mode again. Divided rates and the external tick are exercised by driving identical register writes into all three variants and comparing how far each count moved.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int MODE_W = 16;

    typedef enum logic [1:0] {
        A_COUNT  = 2'd0,
        A_MODE   = 2'd1,
        A_TARGET = 2'd2
    } reg_addr_e;

    localparam int B_STOP      = 0;
    localparam int B_RESET_TGT = 3;
    localparam int B_IRQ_TGT   = 4;
    localparam int B_IRQ_OVF   = 5;
    localparam int B_REPEAT    = 6;
    localparam int B_ALT       = 8;
    localparam int B_DIV8      = 9;
    localparam int B_EVT       = 10;
    localparam int B_HIT_TGT   = 11;
    localparam int B_HIT_OVF   = 12;

    localparam logic [MODE_W-1:0] MODE_WMASK = 16'h1FFF;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int CHAN  = 0,
    parameter int DIV_A = 5,
    parameter int DIV_B = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic alt_sel,
    input  logic div_sel,
    input  logic stop,
    input  logic alt_tick,
    output logic tick
);
    localparam int DIV = (CHAN == 0) ? DIV_A : DIV_B;
    localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] ph;
    } pre_st_t;

    pre_st_t s_d, s_q;
    logic    wrap;
    logic    slow;

    assign wrap = (s_q.ph == PW'(DIV - 1));

    always_comb begin
        s_d = s_q;
        if (clr || wrap) begin
            s_d.ph = '0;
        end else begin
            s_d.ph = s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign slow = (CHAN == 0) ? alt_sel : ((CHAN == 2) ? div_sel : 1'b0);

    assign tick = (CHAN == 1) ? (alt_sel ? alt_tick : 1'b1) :
                  (CHAN == 0) ? (!alt_sel || wrap) :
                                (!stop && (!div_sel || wrap));

    // R9: a divided rate never advances on two cycles in a row
    p_div_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slow && tick && !clr) |=> !tick);
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic rpt,
    input  logic rearm,
    output logic irq
);
    typedef struct packed {
        logic fired;
        logic irq;
    } gate_st_t;

    gate_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = req && (rpt || !s_q.fired);
        if (rearm) begin
            s_d.fired = 1'b0;
        end else if (s_d.irq) begin
            s_d.fired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.irq;

    // R6: once fired in one-shot mode, no further pulse until rearmed
    p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rpt && s_q.fired && !rearm) |=> !irq);

    // R5: a pulse always follows a request of the previous cycle
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req) |=> !irq);
endmodule

// File: rtl/tgt_timer.sv
module tgt_timer #(
    parameter int CW      = 16,
    parameter int CHAN    = 0,
    parameter int NIRQ    = 3,
    parameter int IRQ_IDX = 0,
    parameter int DIV_A   = 5,
    parameter int DIV_B   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [CW-1:0]   wdata,
    input  logic            alt_tick,
    output logic [CW-1:0]   rdata,
    output logic [NIRQ-1:0] irq_vec
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [CW-1:0]     count;
        logic [CW-1:0]     target;
        logic [MODE_W-1:0] mode;
    } tmr_st_t;

    tmr_st_t     s_d, s_q;
    logic        cnt_wr, mode_wr, tgt_wr, mode_rd;
    logic        tick, advance;
    logic [CW:0] inc;
    logic        tgt_hit, ovf_hit, irq_req, irq;

    assign cnt_wr  = wr_en && (addr == A_COUNT);
    assign mode_wr = wr_en && (addr == A_MODE);
    assign tgt_wr  = wr_en && (addr == A_TARGET);
    assign mode_rd = rd_en && (addr == A_MODE);

    tmr_prescale #(
        .CHAN  (CHAN),
        .DIV_A (DIV_A),
        .DIV_B (DIV_B)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mode_wr),
        .alt_sel  (s_q.mode[B_ALT]),
        .div_sel  (s_q.mode[B_DIV8]),
        .stop     (s_q.mode[B_STOP]),
        .alt_tick (alt_tick),
        .tick     (tick)
    );

    assign advance = tick && !cnt_wr && !mode_wr;
    assign inc     = {1'b0, s_q.count} + 1'b1;
    assign tgt_hit = advance && (inc == {1'b0, s_q.target});
    assign ovf_hit = advance && (s_q.count == {CW{1'b1}});
    assign irq_req = (tgt_hit && s_q.mode[B_IRQ_TGT]) ||
                     (ovf_hit && s_q.mode[B_IRQ_OVF]);

    always_comb begin
        s_d = s_q;
        if (advance) begin
            if (tgt_hit && s_q.mode[B_RESET_TGT]) begin
                s_d.count = '0;
            end else begin
                s_d.count = inc[CW-1:0];
            end
        end
        if (mode_rd) begin
            s_d.mode[B_HIT_TGT] = 1'b0;
            s_d.mode[B_HIT_OVF] = 1'b0;
        end
        if (tgt_hit) begin
            s_d.mode[B_HIT_TGT] = 1'b1;
            s_d.mode[B_EVT]     = 1'b1;
        end
        if (ovf_hit) begin
            s_d.mode[B_HIT_OVF] = 1'b1;
            s_d.mode[B_EVT]     = 1'b1;
        end
        if (tgt_wr) begin
            s_d.target = wdata;
        end
        if (mode_wr) begin
            s_d.mode  = MODE_W'(wdata) & MODE_WMASK;
            s_d.count = '0;
        end
        if (cnt_wr) begin
            s_d.count = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    tmr_irq_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_req),
        .rpt   (s_q.mode[B_REPEAT]),
        .rearm (mode_wr),
        .irq   (irq)
    );

    always_comb begin
        case (addr)
            A_COUNT:  rdata = s_q.count;
            A_MODE:   rdata = CW'(s_q.mode);
            A_TARGET: rdata = s_q.target;
            default:  rdata = '0;
        endcase
    end

    generate
        for (genvar i = 0; i < NIRQ; i++) begin : g_irq
            if (i == IRQ_IDX) begin : g_own
                assign irq_vec[i] = irq;
            end else begin : g_other
                assign irq_vec[i] = 1'b0;
            end
        end
    endgenerate

    // R3: advancing past the top of the range wraps and flags overflow
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && s_q.count == {CW{1'b1}}) |=> (s_q.count == '0 && s_q.mode[B_HIT_OVF]));

    // R8: a mode write restarts the count and clears the upper bits
    p_mode_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr) |=> (s_q.count == '0 && s_q.mode[15:13] == 3'b000));

    // R9: without an advance or a write the count holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr && !mode_wr) |=> $stable(s_q.count));

    // R7: a mode read with no new event leaves the sticky flags clear
    p_rdclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd && !wr_en && !tick) |=> (!s_q.mode[B_HIT_TGT] && !s_q.mode[B_HIT_OVF]));

    // R5: at most the own request bit is ever active
    p_irq_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_vec) && ((irq_vec & ~(NIRQ'(1) << IRQ_IDX)) == '0));
endmodule

// File: tb/tgt_timer_tb_top.sv
`timescale 1ns/1ps
module tgt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic        alt_tick = 1'b0;
    logic [15:0] rd0, rd1, rd2;
    logic [2:0]  iv0, iv1, iv2;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    tgt_timer #(.CHAN(0), .IRQ_IDX(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .alt_tick(alt_tick), .rdata(rd0), .irq_vec(iv0));
    tgt_timer #(.CHAN(1), .IRQ_IDX(1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .alt_tick(alt_tick), .rdata(rd1), .irq_vec(iv1));
    tgt_timer #(.CHAN(2), .IRQ_IDX(2)) dut2_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .alt_tick(alt_tick), .rdata(rd2), .irq_vec(iv2));

    typedef struct packed {
        logic [15:0] mode;
        logic [15:0] tgt;
        logic [15:0] init;
        logic [7:0]  n;
        logic [15:0] ecnt;
        logic [15:0] emode;
        logic [3:0]  eirq;
    } vec_t;

    localparam vec_t VT [7] = '{
        '{16'h0020, 16'h0000, 16'hFFFC, 8'd10, 16'h0006, 16'h1420, 4'd1},
        '{16'h0058, 16'h0004, 16'h0000, 8'd12, 16'h0000, 16'h0C58, 4'd3},
        '{16'h0018, 16'h0004, 16'h0000, 8'd12, 16'h0000, 16'h0C18, 4'd1},
        '{16'h0010, 16'h0005, 16'h0003, 8'd4,  16'h0007, 16'h0C10, 4'd1},
        '{16'h0070, 16'hFFFE, 16'hFFFD, 8'd5,  16'h0002, 16'h1C70, 4'd2},
        '{16'h0008, 16'h0000, 16'hFFFE, 8'd3,  16'h0001, 16'h1408, 4'd0},
        '{16'h0028, 16'hFFFF, 16'hFFFD, 8'd4,  16'h0002, 16'h0C28, 4'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a);
        addr = a;
        #1;
    endtask

    task automatic rd_mode_clr(output logic [15:0] v);
        addr = 2'd1; rd_en = 1'b1;
        #1;
        v = rd0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    int irqs;
    int stray;
    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (iv0[0]) irqs++;
            if (iv0[2:1] != 2'b00) stray++;
        end
    endtask

    initial begin
        logic [15:0] v;
        // R1: reset state
        @(negedge clk);
        peek(2'd0); chk("R1 count", rd0, 16'h0);
        peek(2'd1); chk("R1 mode", rd0, 16'h0);
        peek(2'd2); chk("R1 target", rd0, 16'h0);
        chk("R1 irq", {iv2, iv1, iv0}, 9'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector walk: R3 R4 R5 R6 R7
        for (int i = 0; i < 7; i++) begin
            wr(2'd2, VT[i].tgt);
            wr(2'd1, VT[i].mode);
            wr(2'd0, VT[i].init);
            irqs = 0; stray = 0;
            run(int'(VT[i].n));
            peek(2'd0);
            chk($sformatf("R3/R4 count vec%0d", i), rd0, VT[i].ecnt);
            chk($sformatf("R5/R6 irq pulses vec%0d", i), irqs, VT[i].eirq);
            chk($sformatf("R5 other irq bits vec%0d", i), stray, 0);
            rd_mode_clr(v);
            chk($sformatf("R7 mode flags vec%0d", i), v, VT[i].emode);
            peek(2'd1);
            chk($sformatf("R7 flags cleared vec%0d", i), rd0, VT[i].emode & 16'hE7FF);
        end

        // R8: upper mode bits forced to zero; R7 read clear
        wr(2'd1, 16'hFFFF);
        peek(2'd1); chk("R8 mode store", rd0, 16'h1FFF);
        rd_mode_clr(v);
        chk("R7 read value", v, 16'h1FFF);
        peek(2'd1); chk("R7 after read", rd0, 16'h07FF);
        run(20);
        peek(2'd0); chk("R9 stopped variant 2", rd2, 16'h0);
        // R2: count write
        wr(2'd0, 16'hABCD);
        peek(2'd0); chk("R2 count load", rd0, 16'hABCD);
        run(4);
        peek(2'd0); chk("R9 stopped after load", rd2, 16'hABCD);

        // R9: divide by five, line tick, bit 8 on variant 2
        wr(2'd1, 16'h0100);
        run(23);
        peek(2'd0);
        chk("R9 div5 variant 0", rd0, 16'd4);
        chk("R9 idle line variant 1", rd1, 16'd0);
        chk("R9 full rate variant 2", rd2, 16'd23);
        for (int k = 0; k < 3; k++) begin
            alt_tick = 1'b1;
            @(negedge clk);
            alt_tick = 1'b0;
            @(negedge clk);
        end
        peek(2'd0); chk("R9 line ticks variant 1", rd1, 16'd3);

        // R9: divide by eight
        wr(2'd1, 16'h0200);
        run(20);
        peek(2'd0);
        chk("R9 div8 variant 2", rd2, 16'd2);
        chk("R9 full rate variant 0", rd0, 16'd20);
        chk("R9 full rate variant 1", rd1, 16'd20);

        // R10: target write keeps the count
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0008);
        wr(2'd0, 16'd10);
        wr(2'd2, 16'd12);
        peek(2'd0); chk("R10 count kept", rd0, 16'd11);
        run(1);
        peek(2'd0); chk("R10 new target reset", rd0, 16'd0);
        peek(2'd1); chk("R10 target flag", rd0, 16'h0C08);

        // R5: own line, single cycle; R6 repeat
        wr(2'd1, 16'h0060);
        wr(2'd0, 16'hFFFF);
        chk("R5 no pulse before wrap", {iv2, iv1, iv0}, 9'h0);
        @(negedge clk);
        chk("R5 line variant 0", iv0, 3'b001);
        chk("R5 line variant 1", iv1, 3'b010);
        chk("R5 line variant 2", iv2, 3'b100);
        @(negedge clk);
        chk("R5 single cycle", {iv2, iv1, iv0}, 9'h0);
        wr(2'd0, 16'hFFFF);
        @(negedge clk);
        chk("R6 repeat fires again", iv0, 3'b001);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule